// File: doc/BRIEF.md
# BCD Calendar Clock with Alarm

This block keeps wall-clock time and date for a chip that sees a slow reference pulse at 32.768 kHz. It divides the reference down to a once-per-second tick. The tick advances six BCD counters: seconds, minutes, hours in 24-hour form, day of month, month and two-digit year. The calendar follows the true month lengths. Every year whose two-digit value is a multiple of four is a leap year, which is correct for the years 2000 through 2099.

The host reaches the block through a plain register strobe port. A write strobe carries an address and a data byte. Reads are combinational from a separate read address. Time writes land in a holding copy, and a single transfer command loads that copy into the running counters together. Time reads come from a snapshot that is taken when the host raises a capture bit. The time therefore never appears torn across a carry.

An alarm comparator checks selected fields of each new second against programmed values. A sticky flag drives an active-low pin. A rate-trim stage lengthens or shortens one second in every period of 64 seconds by a programmed number of reference pulses. An untrimmed 512 Hz test output lets the crystal be measured without the trim being visible on it.

Top module: `bcd_rtc`

## Requirements
- R1: Every time field is BCD, with the units digit in bits 3:0 and the tens digit in bits 7:4. The ranges are: seconds and minutes 00–59, hours 00–23, day 01 to the last day of the month, month 01–12, year 00–99. Reset loads 00:00:00, day 01, month 01, year 00.
- R2: One second tick occurs every 2^DIV_BITS reference pulses. Seconds roll 59→00 and carry into minutes, minutes carry into hours, and hours roll 23→00 and carry into the day.
- R3: April, June, September and November have 30 days, and the other months except February have 31. February has 29 days when the year value is a multiple of four, including 00, and 28 otherwise. Day 31 of month 12 of year 99 advances to day 01, month 01, year 00.
- R4: The control register is at address 0. Writing it with bit 0 = 1 while the stored capture bit is 0 copies the running time into the snapshot. Reads of addresses 2–7 (seconds, minutes, hours, day, month, year) return the snapshot. Writing bit 0 = 1 again while it is already 1 takes no new capture.
- R5: Writes to addresses 2–7 change only the holding copy. A control write with bit 1 = 1 loads the whole holding copy into the counters at once, and it also zeroes the sub-second divider and the test-output prescaler, so the next tick comes 2^DIV_BITS pulses later.
- R6: Alarm registers sit at addresses 8–12 in the order seconds, minutes, hours, day, month. In each one, bit 7 enables the match and bits 6:0 hold the BCD value. On a tick, the flag sets when every enabled field equals the new time. With no field enabled the flag sets on every tick.
- R7: The alarm flag stays set until the host writes the control register with bit 2 = 1. The flag reads back as control bit 2, and alarm_n is low exactly while the flag is set. A set caused by a tick takes priority over a clear in the same cycle.
- R8: test_tap is the top bit of a free-running prescaler of TAP_BITS bits clocked by the reference, so it has a period of 2^TAP_BITS pulses (512 Hz by default). The trim setting never changes it.
- R9: The calibration register is at address 1. Its magnitude is in bits CAL_BITS-1:0 and its sign is in bit 7, where 1 means add. At the tick that ends each 2^PERIOD_BITS-second period, the next magnitude reference pulses each advance the divider by two (add) or by zero (remove). That second is shortened or lengthened by the magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference period |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 8 | Register read data, combinational |
| test_tap | output | 1 | Untrimmed square wave at the reference divided by 2^TAP_BITS |
| alarm_n | output | 1 | Active-low alarm, low while the alarm flag is set |

## Verification
The bench loads times that sit one or two seconds before each calendar edge and reads the result back through a snapshot:
- a leap February in year 24 and in year 00;
- a common February;
- a 30-day month;
- the wrap from year 99 to year 00.

A design that got the leap rule or the month table wrong would land on day 29, 30 or 31 of the wrong month, or would skip a day.

The bench also times the alarm pin edge to the exact cycle after a transfer. A divider that is not cleared, or that is off by one, shows up as a shifted fall.

It also checks three more things:
- A repeated capture write, or a time write without a transfer, must leave the visible time unchanged.
- A seconds-only match must not refire while a minute match is pending.
- With trim set, exactly one second per period is 251 or 261 cycles long, while the test tap keeps its cadence, which catches a trim applied in the wrong direction or on the wrong side of the tap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] date;
        logic [7:0] mon;
        logic [7:0] year;
    } rtc_time_t;

    localparam rtc_time_t TIME_AT_RESET = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};

    localparam logic [3:0] A_CTRL = 4'd0;
    localparam logic [3:0] A_CAL  = 4'd1;
    localparam logic [3:0] A_SEC  = 4'd2;
    localparam logic [3:0] A_MIN  = 4'd3;
    localparam logic [3:0] A_HOUR = 4'd4;
    localparam logic [3:0] A_DATE = 4'd5;
    localparam logic [3:0] A_MON  = 4'd6;
    localparam logic [3:0] A_YEAR = 4'd7;
    localparam int         A_ALM0 = 8;
    localparam int         ALM_N  = 5;

    // next BCD value, digits only (caller handles range wrap)
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // year value (tens*10+units) is a multiple of four when units+2*tens is
    function automatic logic is_leap(input logic [7:0] y);
        logic [5:0] s;
        s = {2'b00, y[3:0]} + {1'b0, y[7:4], 1'b0};
        return (s[1:0] == 2'b00);
    endfunction

    function automatic logic [7:0] month_last(input logic [7:0] m, input logic [7:0] y);
        case (m)
            8'h02:                      return is_leap(y) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_timebase.sv
module rtc_timebase #(
    parameter int DIV_BITS    = 15,
    parameter int TAP_BITS    = 6,
    parameter int PERIOD_BITS = 6,
    parameter int CAL_BITS    = 5
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ref_tick,
    input  logic                clear,
    input  logic                cal_add,
    input  logic [CAL_BITS-1:0] cal_mag,
    output logic                sec_tick,
    output logic                tap_out
);
    typedef struct packed {
        logic [TAP_BITS-1:0]    pre;
        logic [DIV_BITS-1:0]    div;
        logic [PERIOD_BITS-1:0] period;
        logic [CAL_BITS-1:0]    trim;
    } tb_state_t;

    tb_state_t st_d, st_q;
    logic [1:0]        step;
    logic [DIV_BITS:0] sum;

    always_comb begin
        st_d     = st_q;
        sec_tick = 1'b0;
        step     = 2'd1;
        sum      = '0;
        if (clear) begin
            st_d.pre = '0;
            st_d.div = '0;
        end else if (ref_tick) begin
            st_d.pre = st_q.pre + 1'b1;
            if (st_q.trim != '0) begin
                step      = cal_add ? 2'd2 : 2'd0;
                st_d.trim = st_q.trim - 1'b1;
            end
            sum      = {1'b0, st_q.div} + {{(DIV_BITS-1){1'b0}}, step};
            st_d.div = sum[DIV_BITS-1:0];
            sec_tick = sum[DIV_BITS];
            if (sum[DIV_BITS]) begin
                st_d.period = st_q.period + 1'b1;
                if (&st_q.period) st_d.trim = cal_mag;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tap_out = st_q.pre[TAP_BITS-1];

endmodule

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      load,
    input  rtc_time_t load_time,
    output rtc_time_t cur,
    output rtc_time_t adv
);
    rtc_time_t t_d, t_q;

    always_comb begin
        adv = t_q;
        if (t_q.sec >= 8'h59) begin
            adv.sec = 8'h00;
            if (t_q.min >= 8'h59) begin
                adv.min = 8'h00;
                if (t_q.hour >= 8'h23) begin
                    adv.hour = 8'h00;
                    if (t_q.date >= month_last(t_q.mon, t_q.year)) begin
                        adv.date = 8'h01;
                        if (t_q.mon >= 8'h12) begin
                            adv.mon  = 8'h01;
                            adv.year = (t_q.year >= 8'h99) ? 8'h00 : bcd_inc(t_q.year);
                        end else begin
                            adv.mon = bcd_inc(t_q.mon);
                        end
                    end else begin
                        adv.date = bcd_inc(t_q.date);
                    end
                end else begin
                    adv.hour = bcd_inc(t_q.hour);
                end
            end else begin
                adv.min = bcd_inc(t_q.min);
            end
        end else begin
            adv.sec = bcd_inc(t_q.sec);
        end

        if (load)      t_d = load_time;
        else if (tick) t_d = adv;
        else           t_d = t_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= TIME_AT_RESET;
        else        t_q <= t_d;
    end

    assign cur = t_q;

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  rtc_time_t             adv,
    input  logic [ALM_N-1:0][7:0] alm,
    input  logic                  clr,
    output logic                  flag
);
    logic                  flag_d, flag_q;
    logic                  hit;
    logic [ALM_N-1:0][7:0] fld;

    always_comb begin
        fld = {adv.mon, adv.date, adv.hour, adv.min, adv.sec};
        hit = 1'b1;
        for (int k = 0; k < ALM_N; k++) begin
            if (alm[k][7] && ({1'b0, alm[k][6:0]} != fld[k])) hit = 1'b0;
        end
        if (tick && hit) flag_d = 1'b1;
        else if (clr)    flag_d = 1'b0;
        else             flag_d = flag_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

endmodule

// File: rtl/bcd_rtc.sv
module bcd_rtc
    import rtc_pkg::*;
#(
    parameter int DIV_BITS    = 15,
    parameter int TAP_BITS    = 6,
    parameter int PERIOD_BITS = 6,
    parameter int CAL_BITS    = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_tick,
    input  logic       wr_en,
    input  logic [3:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [3:0] rd_addr,
    output logic [7:0] rd_data,
    output logic       test_tap,
    output logic       alarm_n
);
    typedef struct packed {
        logic                  snap;
        logic                  cal_add;
        logic [CAL_BITS-1:0]   cal_mag;
        rtc_time_t             hold;
        rtc_time_t             shot;
        logic [ALM_N-1:0][7:0] alm;
    } host_t;

    host_t     host_d, host_q;
    rtc_time_t cur_time, adv_time;
    logic      sec_tick, ctrl_wr, xfer, flag_clr, flag;

    assign ctrl_wr  = wr_en && (wr_addr == A_CTRL);
    assign xfer     = ctrl_wr && wr_data[1];
    assign flag_clr = ctrl_wr && wr_data[2];

    rtc_timebase #(
        .DIV_BITS(DIV_BITS), .TAP_BITS(TAP_BITS),
        .PERIOD_BITS(PERIOD_BITS), .CAL_BITS(CAL_BITS)
    ) u_tb (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .clear(xfer),
        .cal_add(host_q.cal_add), .cal_mag(host_q.cal_mag),
        .sec_tick(sec_tick), .tap_out(test_tap)
    );

    rtc_calendar u_cal (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .load(xfer),
        .load_time(host_q.hold), .cur(cur_time), .adv(adv_time)
    );

    rtc_alarm u_alm (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .adv(adv_time),
        .alm(host_q.alm), .clr(flag_clr), .flag(flag)
    );

    always_comb begin
        host_d = host_q;
        if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    host_d.snap = wr_data[0];
                    if (wr_data[0] && !host_q.snap) host_d.shot = cur_time;
                end
                A_CAL: begin
                    host_d.cal_add = wr_data[7];
                    host_d.cal_mag = wr_data[CAL_BITS-1:0];
                end
                A_SEC:  host_d.hold.sec  = wr_data;
                A_MIN:  host_d.hold.min  = wr_data;
                A_HOUR: host_d.hold.hour = wr_data;
                A_DATE: host_d.hold.date = wr_data;
                A_MON:  host_d.hold.mon  = wr_data;
                A_YEAR: host_d.hold.year = wr_data;
                default: begin
                    for (int k = 0; k < ALM_N; k++) begin
                        if (wr_addr == 4'(A_ALM0 + k)) host_d.alm[k] = wr_data;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_q      <= '0;
            host_q.hold <= TIME_AT_RESET;
            host_q.shot <= TIME_AT_RESET;
        end else begin
            host_q <= host_d;
        end
    end

    always_comb begin
        rd_data = 8'h00;
        case (rd_addr)
            A_CTRL: rd_data = {5'b0, flag, 1'b0, host_q.snap};
            A_CAL: begin
                rd_data[CAL_BITS-1:0] = host_q.cal_mag;
                rd_data[7]            = host_q.cal_add;
            end
            A_SEC:  rd_data = host_q.shot.sec;
            A_MIN:  rd_data = host_q.shot.min;
            A_HOUR: rd_data = host_q.shot.hour;
            A_DATE: rd_data = host_q.shot.date;
            A_MON:  rd_data = host_q.shot.mon;
            A_YEAR: rd_data = host_q.shot.year;
            default: begin
                for (int k = 0; k < ALM_N; k++) begin
                    if (rd_addr == 4'(A_ALM0 + k)) rd_data = host_q.alm[k];
                end
            end
        endcase
    end

    assign alarm_n = ~flag;

endmodule

// File: rtl/rtc_checks.sv
module rtc_checks
    import rtc_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       load,
    input logic       clr,
    input logic       wr_en,
    input logic [3:0] wr_addr,
    input logic       alarm_n,
    input rtc_time_t  cur,
    input rtc_time_t  hold,
    input rtc_time_t  shot
);
    assert_sec_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load && cur.sec <= 8'h59 && cur.sec[3:0] <= 4'd9)
        |=> (cur.sec <= 8'h59 && cur.sec[3:0] <= 4'd9));

    assert_min_carry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_tick && !load && cur.sec == 8'h59)
        |=> (cur.sec == 8'h00 && cur.min != $past(cur.min)));

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !load) |=> $stable(cur));

    assert_snap_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_CTRL) |=> $stable(shot));

    assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cur == $past(hold)));

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_n && !clr) |=> !alarm_n);

endmodule

bind bcd_rtc rtc_checks u_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .load(xfer), .clr(flag_clr),
    .wr_en(wr_en), .wr_addr(wr_addr), .alarm_n(alarm_n), .cur(cur_time),
    .hold(host_q.hold), .shot(host_q.shot)
);

// File: tb/bcd_rtc_tb.sv
module bcd_rtc_tb;
    localparam int DIV  = 8;
    localparam int TAP  = 3;
    localparam int PER  = 6;
    localparam int CALB = 5;
    localparam int SEC  = 1 << DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [3:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       test_tap, alarm_n;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    bcd_rtc #(.DIV_BITS(DIV), .TAP_BITS(TAP), .PERIOD_BITS(PER), .CAL_BITS(CALB)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .test_tap(test_tap), .alarm_n(alarm_n)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int b2i(input logic [7:0] b);
        return int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    function automatic logic [7:0] i2b(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int days_in(input int mo, input int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    // behavioural reference model (binary time, integer counters)
    int m_pre, m_div, m_per, m_trim, m_mag, m_step;
    bit m_add, m_snap, m_flag, m_tick, m_xf, m_cl, m_hit;
    int m_t[6];
    logic [7:0] m_hold[6];
    logic [7:0] m_shot[6];
    logic [7:0] m_alm[5];
    logic [7:0] m_oa[5];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pre = 0; m_div = 0; m_per = 0; m_trim = 0; m_mag = 0; m_add = 0;
            m_snap = 0; m_flag = 0;
            m_t = '{0, 0, 0, 1, 1, 0};
            m_hold = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
            m_shot = '{8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00};
            m_alm = '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00};
        end else begin
            m_xf = wr_en && wr_addr == 4'd0 && wr_data[1];
            m_cl = wr_en && wr_addr == 4'd0 && wr_data[2];
            m_oa = m_alm;
            m_tick = 0;
            if (m_xf) begin
                m_pre = 0; m_div = 0;
            end else if (ref_tick) begin
                m_pre = (m_pre + 1) % (1 << TAP);
                m_step = 1;
                if (m_trim > 0) begin m_step = m_add ? 2 : 0; m_trim--; end
                m_div += m_step;
                if (m_div >= SEC) begin
                    m_div -= SEC;
                    m_tick = 1;
                    if (m_per == (1 << PER) - 1) m_trim = m_mag;
                    m_per = (m_per + 1) % (1 << PER);
                end
            end
            if (wr_en) begin
                if (wr_addr == 4'd0) begin
                    if (wr_data[0] && !m_snap) for (int k = 0; k < 6; k++) m_shot[k] = i2b(m_t[k]);
                    m_snap = wr_data[0];
                end else if (wr_addr == 4'd1) begin
                    m_mag = int'(wr_data[CALB-1:0]); m_add = wr_data[7];
                end else if (wr_addr <= 4'd7) begin
                    m_hold[int'(wr_addr) - 2] = wr_data;
                end else if (wr_addr <= 4'd12) begin
                    m_alm[int'(wr_addr) - 8] = wr_data;
                end
            end
            if (m_xf) begin
                for (int k = 0; k < 6; k++) m_t[k] = b2i(m_hold[k]);
            end else if (m_tick) begin
                m_t[0]++;
                if (m_t[0] == 60) begin
                    m_t[0] = 0; m_t[1]++;
                    if (m_t[1] == 60) begin
                        m_t[1] = 0; m_t[2]++;
                        if (m_t[2] == 24) begin
                            m_t[2] = 0; m_t[3]++;
                            if (m_t[3] > days_in(m_t[4], m_t[5])) begin
                                m_t[3] = 1; m_t[4]++;
                                if (m_t[4] > 12) begin
                                    m_t[4] = 1; m_t[5] = (m_t[5] + 1) % 100;
                                end
                            end
                        end
                    end
                end
            end
            m_hit = 1;
            for (int k = 0; k < 5; k++)
                if (m_oa[k][7] && b2i({1'b0, m_oa[k][6:0]}) != m_t[k]) m_hit = 0;
            if (m_tick && m_hit) m_flag = 1;
            else if (m_cl)       m_flag = 0;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            check(32'(alarm_n), 32'(!m_flag), "R6/R7 alarm pin vs model");
            check(32'(test_tap), 32'((m_pre >> (TAP - 1)) & 1), "R8 test tap vs model");
        end
    end

    task automatic finish_run;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, d, mo, y);
        wr(4'd2, s); wr(4'd3, mi); wr(4'd4, h);
        wr(4'd5, d); wr(4'd6, mo); wr(4'd7, y);
        wr(4'd0, 8'h06);
    endtask

    task automatic expect_time(input logic [7:0] s, mi, h, d, mo, y, input string tag);
        logic [7:0] v;
        logic [7:0] e[6];
        e = '{s, mi, h, d, mo, y};
        wr(4'd0, 8'h00);
        wr(4'd0, 8'h01);
        for (int k = 0; k < 6; k++) begin
            rd(4'(k + 2), v);
            check(32'(v), 32'(e[k]), $sformatf("%s field %0d", tag, k));
        end
    endtask

    task automatic trim_run(input int n, input int alt, output int saw);
        int last;
        last = -1;
        saw = 0;
        for (int c = 0; c < n; c++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (!alarm_n) begin
                if (last >= 0) begin
                    if (c - last == alt) saw++;
                    else check(32'(c - last), 32'(SEC), "R9 second length outside trim");
                end
                last = c;
                wr_en = 1'b1; wr_addr = 4'd0; wr_data = 8'h04;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        logic [7:0] v, s1;
        int saw;
        wait_cyc(4);
        // R1 reset state
        rd(4'd0, v); check(32'(v), 32'h00, "R1 reset ctrl");
        rd(4'd1, v); check(32'(v), 32'h00, "R1 reset cal");
        rd(4'd5, v); check(32'(v), 32'h01, "R1 reset day");
        rd(4'd6, v); check(32'(v), 32'h01, "R1 reset month");
        check(32'(alarm_n), 32'h1, "R1 reset alarm_n");
        rst_n = 1'b1;
        ref_tick = 1'b1;

        // R3 leap February, year 24
        set_time(8'h58, 8'h59, 8'h23, 8'h28, 8'h02, 8'h24);
        wait_cyc(2 * SEC + 20);
        expect_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h24, "R3 leap day 24");
        // R3 common February
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h23);
        wait_cyc(SEC + 20);
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h03, 8'h23, "R3 common Feb end");
        // R3 year 00 is leap
        set_time(8'h59, 8'h59, 8'h23, 8'h28, 8'h02, 8'h00);
        wait_cyc(SEC + 20);
        expect_time(8'h00, 8'h00, 8'h00, 8'h29, 8'h02, 8'h00, "R3 leap day 00");
        // R3 30-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h30, 8'h04, 8'h21);
        wait_cyc(SEC + 20);
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h05, 8'h21, "R3 April end");
        // R3 century wrap
        set_time(8'h59, 8'h59, 8'h23, 8'h31, 8'h12, 8'h99);
        wait_cyc(SEC + 20);
        expect_time(8'h00, 8'h00, 8'h00, 8'h01, 8'h01, 8'h00, "R3 year 99 wrap");
        // R2 hour carry inside a day
        set_time(8'h59, 8'h59, 8'h22, 8'h15, 8'h06, 8'h21);
        wait_cyc(SEC + 20);
        expect_time(8'h00, 8'h00, 8'h23, 8'h15, 8'h06, 8'h21, "R2 hour carry");

        // R5 holding copy is not live
        set_time(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h21);
        wait_cyc(100);
        wr(4'd2, 8'h45);
        expect_time(8'h30, 8'h20, 8'h10, 8'h15, 8'h06, 8'h21, "R5 hold write ignored");
        // R5 transfer restarts divider: tick exactly SEC cycles later
        wr(4'd0, 8'h06);
        wait_cyc(SEC - 1);
        check(32'(alarm_n), 32'h1, "R5 no tick before full second");
        wait_cyc(1);
        check(32'(alarm_n), 32'h0, "R2/R5 tick at full second");
        expect_time(8'h46, 8'h20, 8'h10, 8'h15, 8'h06, 8'h21, "R5 loaded seconds");

        // R4 snapshot held; re-set without clear takes no capture
        wr(4'd0, 8'h00); wr(4'd0, 8'h01);
        rd(4'd2, s1);
        wait_cyc(300);
        rd(4'd2, v); check(32'(v), 32'(s1), "R4 snapshot held");
        wr(4'd0, 8'h01);
        rd(4'd2, v); check(32'(v), 32'(s1), "R4 second set no capture");
        wr(4'd0, 8'h00); wr(4'd0, 8'h01);
        rd(4'd2, v); check(32'(v), 32'(m_shot[0]), "R4 fresh capture");
        check(32'(v != s1), 32'h1, "R4 fresh capture differs");

        // R6 seconds match
        wr(4'd8, 8'h85);
        set_time(8'h02, 8'h00, 8'h00, 8'h01, 8'h01, 8'h22);
        wait_cyc(3 * SEC - 1);
        check(32'(alarm_n), 32'h1, "R6 before seconds match");
        wait_cyc(1);
        check(32'(alarm_n), 32'h0, "R6 fires on seconds match");
        rd(4'd0, v); check(32'(v[2]), 32'h1, "R7 flag readable");
        wait_cyc(600);
        check(32'(alarm_n), 32'h0, "R7 flag sticky");
        wr(4'd0, 8'h04);
        check(32'(alarm_n), 32'h1, "R7 cleared");
        rd(4'd0, v); check(32'(v[2]), 32'h0, "R7 flag bit cleared");
        // R6 seconds + minutes: no fire at 00:01:05
        wr(4'd9, 8'h82);
        wait_cyc(70 * SEC);
        check(32'(alarm_n), 32'h1, "R6 minute gate holds off");
        wait_cyc(60 * SEC);
        check(32'(alarm_n), 32'h0, "R6 fires at 00:02:05");
        wr(4'd8, 8'h00); wr(4'd9, 8'h00);
        wr(4'd0, 8'h04);

        // R9 trim add then remove
        wr(4'd1, 8'h85);
        rd(4'd1, v); check(32'(v), 32'h85, "R9 cal readback");
        trim_run(70 * SEC, SEC - 5, saw);
        check(32'(saw), 32'h1, "R9 one shortened second per period");
        wr(4'd1, 8'h05);
        trim_run(70 * SEC, SEC + 5, saw);
        check(32'(saw), 32'h1, "R9 one lengthened second per period");

        finish_run();
    end

endmodule